// File: doc/BRIEF.md
# Angular histogram accumulator

This block counts accepted particle tracks by direction. Each track arrives as a one-cycle strobe with two 5-bit position differences, one from the horizontal strips and one from the vertical strips. The pair is joined into a 10-bit bin index into a 1024-entry on-chip memory of 32-bit counters, and the indexed counter goes up by one. Increments run through a two-stage read-modify-write pipeline. A bypass path makes sure that strobes arriving on consecutive cycles for the same bin are all counted.

A second, independent read port lets a network-side reader fetch any bin while counting goes on. A clear command starts a sweep that writes zero to every bin, one bin per cycle. While the sweep runs, new tracks are discarded and reads return zero. A one-cycle completion pulse marks the end of the sweep.

Top module: `ang_hist_acc`

## Requirements
- R1: After reset, `rd_valid`, `clr_busy` and `clr_done` are low.
- R2: The bin index is `{ev_hdiff, ev_vdiff}`, with the horizontal difference in bits 9:5 and the vertical difference in bits 4:0.
- R3: Each strobe of `ev_valid` that is accepted adds exactly one to the indexed 32-bit bin.
- R4: Strobes on consecutive cycles, whether to the same bin or alternating between bins, are all counted. No increment is lost.
- R5: A read request sampled at clock edge k drives `rd_valid` high, with `rd_data` holding the bin value, during the cycle after edge k. A strobe sampled at edge j is already included in any read sampled at edge j+2 or later.
- R6: Reads issued on the same cycles as strobes return correct values and do not disturb any count.
- R7: A bin that holds its all-ones value stays at all-ones when further strobes arrive. It never wraps to zero.
- R8: A `clr_req` sampled while idle raises `clr_busy` from the next cycle for exactly 1024 cycles. As `clr_busy` falls, `clr_done` is high for exactly one cycle, and after that every bin reads zero.
- R9: Strobes sampled during the sweep, or on the same edge as the `clr_req` that starts it, are discarded.
- R10: A read request sampled while `clr_busy` is high returns zero, with `rd_valid` high.
- R11: A `clr_req` sampled while `clr_busy` is high is ignored, and the sweep still lasts 1024 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_valid | input | 1 | Track strobe, one per accepted track |
| ev_hdiff | input | 5 | Horizontal position difference (upper bin index) |
| ev_vdiff | input | 5 | Vertical position difference (lower bin index) |
| rd_req | input | 1 | Read request for bin `rd_addr` |
| rd_addr | input | 10 | Bin index to read |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| clr_req | input | 1 | Start a clear sweep |
| clr_busy | output | 1 | Clear sweep in progress |
| clr_done | output | 1 | One-cycle pulse at the end of the sweep |

## Verification
A stale bypass register or a wrong bypass address shows up as a bin that is one or more counts short. The first read issued two cycles after a back-to-back burst to one bin reveals it. A sweep counter that stops early or runs late changes how long `clr_busy` stays high, or leaves nonzero bins that a read exposes right after `clr_done`. A drop gate that leaks lets a strobe land during the sweep, so the bin it targets is nonzero when read just after the sweep ends. Saturation logic that is wrong lets a narrow instance's counter wrap, and a single read after an overflowing burst shows it.

// File: rtl/ang_hist_acc.sv
`timescale 1ns/1ps
module ang_hist_acc #(
  parameter int FIELD_W = 5,
  parameter int BIN_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  input  logic [FIELD_W-1:0] ev_hdiff,
  input  logic [FIELD_W-1:0] ev_vdiff,
  input  logic               rd_req,
  input  logic [2*FIELD_W-1:0] rd_addr,
  output logic               rd_valid,
  output logic [BIN_W-1:0]   rd_data,
  input  logic               clr_req,
  output logic               clr_busy,
  output logic               clr_done
);
  localparam int ADDR_W = 2 * FIELD_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [BIN_W-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] ev_addr;
  logic              clr_go, accept;
  logic              s1_v, wv;
  logic [ADDR_W-1:0] s1_a, wa, clr_cnt;
  logic [BIN_W-1:0]  s1_q, wd, cur, nxt, rd_q;
  logic              rd_zero;

  assign ev_addr = {ev_hdiff, ev_vdiff};
  assign clr_go  = clr_req && !clr_busy;
  assign accept  = ev_valid && !clr_busy && !clr_go;
  assign cur     = (wv && wa == s1_a) ? wd : s1_q;
  assign nxt     = (&cur) ? cur : cur + 1'b1;
  assign rd_data = rd_zero ? '0 : rd_q;

  always_ff @(posedge clk) begin
    if (clr_busy)  mem[clr_cnt] <= '0;
    else if (s1_v) mem[s1_a]   <= nxt;
    s1_q <= mem[ev_addr];
    rd_q <= mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_a <= '0;
      wv   <= 1'b0; wa   <= '0; wd <= '0;
    end else begin
      s1_v <= accept;
      s1_a <= ev_addr;
      wv   <= s1_v && !clr_busy;
      wa   <= s1_a;
      wd   <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_zero  <= 1'b0;
    end else begin
      rd_valid <= rd_req;
      rd_zero  <= clr_busy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_busy <= 1'b0;
      clr_cnt  <= '0;
      clr_done <= 1'b0;
    end else begin
      clr_done <= 1'b0;
      if (clr_go) begin
        clr_busy <= 1'b1;
        clr_cnt  <= '0;
      end else if (clr_busy) begin
        clr_cnt <= clr_cnt + 1'b1;
        if (&clr_cnt) begin
          clr_busy <= 1'b0;
          clr_done <= 1'b1;
        end
      end
    end
  end

  AST_SWEEP_START: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !clr_busy |=> clr_busy); // R8
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |-> !clr_busy && $past(clr_busy)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |=> !clr_done); // R8
  AST_SWEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy && !(&clr_cnt) |=> clr_busy); // R11
  AST_NO_EVENT_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> !s1_v); // R9
  AST_RD_ZERO_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(clr_busy) |-> rd_data == '0); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wv |-> wd != '0); // R7
endmodule

// File: tb/test_ang_hist_acc.sv
`timescale 1ns/1ps
module test_ang_hist_acc;
  logic clk = 0, rst_n = 0;
  logic ev_valid = 0, rd_req = 0, clr_req = 0;
  logic [4:0] ev_h = 0, ev_v = 0;
  logic [9:0] rd_addr = 0;
  logic rd_valid, clr_busy, clr_done;
  logic [31:0] rd_data;
  logic s_ev_valid = 0, s_rd_req = 0, s_clr_req = 0;
  logic s_rd_valid, s_clr_busy, s_clr_done;
  logic [3:0] s_rd_data;
  int n_cmp = 0, n_mis = 0;
  int unsigned refh [1024];

  always #2.5 clk = ~clk;

  ang_hist_acc i_ang_hist_acc (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_hdiff(ev_h), .ev_vdiff(ev_v),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .clr_req(clr_req), .clr_busy(clr_busy), .clr_done(clr_done));

  ang_hist_acc #(.BIN_W(4)) i_ang_hist_acc_sat (
    .clk(clk), .rst_n(rst_n), .ev_valid(s_ev_valid), .ev_hdiff(ev_h), .ev_vdiff(ev_v),
    .rd_req(s_rd_req), .rd_addr(rd_addr), .rd_valid(s_rd_valid), .rd_data(s_rd_data),
    .clr_req(s_clr_req), .clr_busy(s_clr_busy), .clr_done(s_clr_done));

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic ev_one(input logic [4:0] h, input logic [4:0] v);
    @(negedge clk); ev_valid = 1; ev_h = h; ev_v = v; refh[{h, v}]++;
    @(negedge clk); ev_valid = 0;
  endtask

  task automatic rd_check(input logic [9:0] ra, input logic [31:0] exp, input string rq);
    @(negedge clk); rd_req = 1; rd_addr = ra;
    @(negedge clk); rd_req = 0;
    chk({rq, " rd_valid"}, {31'd0, rd_valid}, 32'd1);
    chk(rq, rd_data, exp);
  endtask

  task automatic do_clear(input bit noise);
    int busy_n = 0;
    bit seen = 0;
    @(negedge clk); clr_req = 1;
    if (noise) begin ev_valid = 1; ev_h = 7; ev_v = 7; end
    @(negedge clk); clr_req = 0;
    for (int i = 0; i < 1100 && !seen; i++) begin
      if (noise && rd_valid) chk("R10 read during sweep", rd_data, 32'd0);
      if (clr_done) seen = 1;
      else if (clr_busy) busy_n++;
      if (noise && !seen) begin
        ev_valid = 1; ev_h = 7; ev_v = 7;
        rd_req = (i < 1000); rd_addr = 10'd1000;
        clr_req = (i == 10);
      end else begin
        ev_valid = 0; rd_req = 0; clr_req = 0;
      end
      if (!seen) @(negedge clk);
    end
    ev_valid = 0; rd_req = 0; clr_req = 0;
    chk("R8 done seen", {31'd0, seen}, 32'd1);
    chk(noise ? "R11 sweep length with repeat request" : "R8 sweep length", busy_n, 32'd1024);
    @(negedge clk);
    chk("R8 done is one pulse", {31'd0, clr_done}, 32'd0);
    foreach (refh[i]) refh[i] = 0;
  endtask

  task automatic t_reset;
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("R1 clr_busy", {31'd0, clr_busy}, 32'd0);
    chk("R1 clr_done", {31'd0, clr_done}, 32'd0);
  endtask

  task automatic t_clear_basic;
    do_clear(0);
    rd_check(10'd0, 0, "R8 bin 0 zero");
    rd_check(10'd1023, 0, "R8 bin 1023 zero");
  endtask

  task automatic t_address;
    ev_one(5'd3, 5'd17);
    rd_check(10'd113, 1, "R2 R3 R5 bin {3,17}");
    rd_check(10'd547, 0, "R2 swapped bin untouched");
    ev_one(5'd3, 5'd17);
    rd_check(10'd113, 2, "R3 second increment");
  endtask

  task automatic t_back2back;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ev_valid = 1;
      if (i < 6 || i[0] == 1'b0) begin ev_h = 31; ev_v = 31; end
      else begin ev_h = 0; ev_v = 0; end
      refh[{ev_h, ev_v}]++;
    end
    @(negedge clk); ev_valid = 0;
    rd_check(10'd1023, 8, "R4 same-bin burst");
    rd_check(10'd0, 2, "R4 alternating bins");
  endtask

  task automatic t_concurrent;
    ev_one(5'd15, 5'd20);
    ev_one(5'd15, 5'd20);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk("R6 rd_valid during counting", {31'd0, rd_valid}, 32'd1);
        chk("R6 read during counting", rd_data, 32'd2);
      end
      if (i < 8) begin
        ev_valid = 1; ev_h = 1; ev_v = 2; refh[34]++;
        rd_req = 1; rd_addr = 10'd500;
      end else begin
        ev_valid = 0; rd_req = 0;
      end
    end
    rd_check(10'd34, 8, "R6 counts beside reads");
    rd_check(10'd500, 2, "R6 read bin unchanged");
  endtask

  task automatic t_clear_noise;
    ev_one(5'd31, 5'd8);
    ev_one(5'd7, 5'd7);
    rd_check(10'd1000, 1, "R3 bin 1000 before sweep");
    do_clear(1);
    rd_check(10'd231, 0, "R9 strobes in sweep dropped");
    rd_check(10'd1000, 0, "R8 bin cleared");
    rd_check(10'd113, 0, "R8 bin 113 cleared");
  endtask

  task automatic t_saturate;
    bit seen = 0;
    @(negedge clk); s_clr_req = 1;
    @(negedge clk); s_clr_req = 0;
    for (int i = 0; i < 1100 && !seen; i++) begin
      if (s_clr_done) seen = 1; else @(negedge clk);
    end
    chk("R8 narrow clear done", {31'd0, seen}, 32'd1);
    for (int i = 0; i < 17; i++) begin
      @(negedge clk); s_ev_valid = 1; ev_h = 0; ev_v = 5;
    end
    @(negedge clk); s_ev_valid = 0;
    @(negedge clk); s_rd_req = 1; rd_addr = 10'd5;
    @(negedge clk); s_rd_req = 0;
    chk("R7 saturated bin", {28'd0, s_rd_data}, 32'd15);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); s_ev_valid = 1;
    end
    @(negedge clk); s_ev_valid = 0;
    @(negedge clk); s_rd_req = 1;
    @(negedge clk); s_rd_req = 0;
    chk("R7 stays saturated", {28'd0, s_rd_data}, 32'd15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_clear_basic();
    t_address();
    t_back2back();
    t_concurrent();
    t_clear_noise();
    t_saturate();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_cmp++; n_mis++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule